// File: doc/BRIEF.md
# Flash Read-Mode Output Selector

This block is the read-side data path of a word-wide flash device. A small read-mode register chooses what the data bus returns. It can return the word supplied by the external array, a fixed identifier code, or a registered copy of the status byte. The bus is driven only during a selected read. Otherwise it stays released, which is shown by a low output-enable flag and an all-zero data word.

On the write side, the block watches the chip-enable and write-enable strobes. The write phase lasts while both strobes are low. When the first of the two strobes goes back high, the block hands the captured address, data word and command byte to an upstream command decoder as a one-cycle strobe. The decoder answers with mode-change requests. The block applies these at a clock edge, and reset always returns the mode to array read.

All strobes are sampled on the block clock, and the reset is synchronous and active high. In signature mode, the identifier returned is chosen by the lowest address bit. The device code depends on whether the part is built as a top-boot or bottom-boot variant.

Top module: `flrd_read_path`

## Requirements
- R1: `dq_en` is high only while `ce_n` and `oe_n` are both low and `rst` is low; whenever `dq_en` is low, `dq_o` is all zeros.
- R2: While `rst` is high, `dq_en` is low whatever the strobes do.
- R3: In the first cycle after `rst` falls, the read mode is array read, including when `mode_set` was high during reset.
- R4: In array mode a driven read returns `arr_data` unchanged.
- R5: In signature mode, `addr[0]` = 0 returns 0x0020 and `addr[0]` = 1 returns the device code: 0x0090 when `TOP_BOOT` = 1, 0x0091 when `TOP_BOOT` = 0.
- R6: The status register samples `status_in` at every clock edge. In status mode a read returns that register in the low byte with zeros above, so a change on `status_in` shows only after the next edge.
- R7: `mode_sel` encodes 0 = array, 1 = signature, 2 = status. It is applied at a clock edge where `mode_set` is high, and reads before that edge keep the old mode. The value 3 leaves the mode unchanged.
- R8: While `ce_n` and `we_n` are both low, `addr` and `din` are tracked. At the first clock where either strobe is sampled high, `wr_stb` pulses for exactly one cycle after that edge. With the pulse, `wr_addr` and `wr_data` show the last values sampled with both strobes low.
- R9: A write phase yields a single `wr_stb` pulse; the later rise of the other strobe produces none.
- R10: `wr_cmd` carries bits 7:0 of the captured data word; the upper byte never reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (device reset) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| arr_data | input | DATA_W | Word read from the external array |
| status_in | input | STAT_W | Live status byte from the controller |
| mode_set | input | 1 | Mode-change request from the command decoder |
| mode_sel | input | 2 | Requested read mode |
| dq_o | output | DATA_W | Read data, zero when not driven |
| dq_en | output | 1 | Bus drive enable (low = high impedance) |
| wr_stb | output | 1 | One-cycle pulse: a write has been latched |
| wr_addr | output | ADDR_W | Latched write address |
| wr_data | output | DATA_W | Latched write word |
| wr_cmd | output | 8 | Command byte (low byte of the latched word) |

## Verification
The properties assume that the command decoder raises `mode_set` only for a single cycle. They also assume that the strobes stay stable between clock samples, so that a write phase is seen as at least one cycle with both strobes low. The stimulus changes every input only at the falling clock edge. Mode requests are held for exactly one cycle, and each write phase is kept low for one or more whole cycles before one strobe or both are released. Reads are made with `we_n` high so that a read and a write never overlap.

// File: rtl/flrd_pkg.sv
package flrd_pkg;

    localparam int CMD_W = 8;

    localparam logic [7:0] MFR_CODE     = 8'h20;
    localparam logic [7:0] DEV_CODE_TOP = 8'h90;
    localparam logic [7:0] DEV_CODE_BOT = 8'h91;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_SIG    = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    // Encoding 3 is reserved and never loaded into the mode register.
    function automatic logic mode_valid(input logic [1:0] sel);
        return sel != 2'd3;
    endfunction

    // Identifier byte: address bit 0 picks manufacturer (0) or device (1).
    function automatic logic [7:0] sig_code(input logic sel_dev, input logic top_boot);
        if (!sel_dev)
            return MFR_CODE;
        return top_boot ? DEV_CODE_TOP : DEV_CODE_BOT;
    endfunction

endpackage

// File: rtl/flrd_wr_latch.sv
module flrd_wr_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic wr_phase;
    logic wr_phase_q;

    // The write phase lasts while both strobes are low; it ends on the first rise.
    assign wr_phase = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_phase_q <= 1'b0;
            wr_stb     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_phase_q <= wr_phase;
            wr_stb     <= wr_phase_q && !wr_phase;
            if (wr_phase) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end

endmodule

// File: rtl/flrd_mode_reg.sv
module flrd_mode_reg
    import flrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_set,
    input  logic [1:0] mode_sel,
    output rd_mode_e   rd_mode
);

    always_ff @(posedge clk) begin
        if (rst)
            rd_mode <= RD_ARRAY;
        else if (mode_set && mode_valid(mode_sel))
            rd_mode <= rd_mode_e'(mode_sel);
    end

endmodule

// File: rtl/flrd_out_mux.sv
module flrd_out_mux
    import flrd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int STAT_W   = 8,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              addr_lsb,
    input  rd_mode_e          rd_mode,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [STAT_W-1:0] status_in,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_en
);

    localparam int SIG_PAD  = DATA_W - 8;
    localparam int STAT_PAD = DATA_W - STAT_W;

    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] rd_word;

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= status_in;
    end

    always_comb begin
        case (rd_mode)
            RD_SIG:    rd_word = {{SIG_PAD{1'b0}}, sig_code(addr_lsb, TOP_BOOT)};
            RD_STATUS: rd_word = {{STAT_PAD{1'b0}}, stat_q};
            default:   rd_word = arr_data;
        endcase
    end

    assign dq_en = !rst && !ce_n && !oe_n;
    assign dq_o  = dq_en ? rd_word : '0;

endmodule

// File: rtl/flrd_read_path.sv
module flrd_read_path
    import flrd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int STAT_W   = 8,
    parameter bit TOP_BOOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [STAT_W-1:0] status_in,
    input  logic              mode_set,
    input  logic [1:0]        mode_sel,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_en,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [CMD_W-1:0]  wr_cmd
);

    rd_mode_e rd_mode;

    flrd_wr_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flrd_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_set (mode_set),
        .mode_sel (mode_sel),
        .rd_mode  (rd_mode)
    );

    flrd_out_mux #(
        .DATA_W   (DATA_W),
        .STAT_W   (STAT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .addr_lsb  (addr[0]),
        .rd_mode   (rd_mode),
        .arr_data  (arr_data),
        .status_in (status_in),
        .dq_o      (dq_o),
        .dq_en     (dq_en)
    );

    // Commands travel on the low byte only.
    assign wr_cmd = wr_data[CMD_W-1:0];

endmodule

// File: rtl/flrd_read_chk.sv
module flrd_read_chk #(
    parameter int DATA_W   = 16,
    parameter int STAT_W   = 8,
    parameter bit TOP_BOOT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              addr0,
    input logic              mode_set,
    input logic [1:0]        mode_sel,
    input logic [DATA_W-1:0] arr_data,
    input logic [STAT_W-1:0] status_in,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_en,
    input logic              wr_stb
);

    localparam logic [7:0] DEV_B = TOP_BOOT ? 8'h90 : 8'h91;

    // R1
    bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dq_en);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dq_en |-> dq_o == '0);

    // R2
    always @(posedge clk) begin
        if (rst) begin
            rst_hiz_chk: assert (!dq_en);
        end
    end

    // R3
    reset_array_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ce_n && !oe_n) |-> dq_o == arr_data);

    // R5
    sig_code_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_set && mode_sel == 2'd1) |=>
            (ce_n || oe_n || dq_o == {{(DATA_W-8){1'b0}}, (addr0 ? DEV_B : 8'h20)}));

    // R6
    status_view_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_set && mode_sel == 2'd2) |=>
            (ce_n || oe_n || dq_o == {{(DATA_W-STAT_W){1'b0}}, $past(status_in)}));

    // R8
    stb_origin_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> ($past(!ce_n && !we_n, 2) && !$past(!ce_n && !we_n)));

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

endmodule

bind flrd_read_path flrd_read_chk #(
    .DATA_W   (DATA_W),
    .STAT_W   (STAT_W),
    .TOP_BOOT (TOP_BOOT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr0     (addr[0]),
    .mode_set  (mode_set),
    .mode_sel  (mode_sel),
    .arr_data  (arr_data),
    .status_in (status_in),
    .dq_o      (dq_o),
    .dq_en     (dq_en),
    .wr_stb    (wr_stb)
);

// File: tb/flrd_read_path_test.sv
`timescale 1ns/1ps
module flrd_read_path_test;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, arr_data;
    logic [SW-1:0] status_in;
    logic          mode_set;
    logic [1:0]    mode_sel;
    logic [DW-1:0] dq_o;
    logic          dq_en, wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [7:0]    wr_cmd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flrd_read_path #(.ADDR_W(AW), .DATA_W(DW), .STAT_W(SW), .TOP_BOOT(1'b1)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .arr_data(arr_data), .status_in(status_in),
        .mode_set(mode_set), .mode_sel(mode_sel), .dq_o(dq_o), .dq_en(dq_en),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_cmd(wr_cmd)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_set = 1'b1;
        mode_sel = m;
        tick();
        mode_set = 1'b0;
    endtask

    // Write phase of len cycles; kind 0: we_n rises first, 1: ce_n first, 2: both.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int kind, input int len);
        oe_n = 1'b1;
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        for (int i = 0; i < len; i++) begin
            tick();
            #1 chk("R9", wr_stb, 1'b0);
        end
        if (kind == 0) we_n = 1'b1;
        else if (kind == 1) ce_n = 1'b1;
        else begin ce_n = 1'b1; we_n = 1'b1; end
        addr = ~a; din = ~d;
        #1 chk("R8", wr_stb, 1'b0);
        tick();
        #1;
        chk("R8", wr_stb, 1'b1);
        chk("R8", wr_addr, a);
        chk("R8", wr_data, d);
        chk("R10", wr_cmd, d[7:0]);
        ce_n = 1'b1; we_n = 1'b1;
        tick();
        #1 chk("R9", wr_stb, 1'b0);
        tick();
        #1 chk("R9", wr_stb, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        addr = '0; din = '0; arr_data = 16'h1234; status_in = '0;
        mode_set = 1'b1; mode_sel = 2'd1;
        @(negedge clk);
        repeat (3) begin
            tick();
            #1;
            chk("R2", dq_en, 1'b0);
            chk("R1", dq_o, 16'h0000);
            chk("R8", wr_stb, 1'b0);
        end
        rst = 1'b0; mode_set = 1'b0;
        #1;
        chk("R3", dq_en, 1'b1);
        chk("R3", dq_o, 16'h1234);

        // R1: drive only with both enables low
        for (int c = 0; c < 4; c++) begin
            ce_n = c[0]; oe_n = c[1];
            arr_data = 16'hBEEF;
            #1;
            chk("R1", dq_en, (c == 0));
            chk("R1", dq_o, (c == 0) ? 16'hBEEF : 16'h0000);
        end
        ce_n = 1'b0; oe_n = 1'b0;

        // R4: array pass-through sweep
        for (int i = 0; i < 64; i++) begin
            arr_data = 16'(i * 16'h0403) ^ 16'hA5C3;
            addr = 20'(i * 20'h1F3D);
            #1 chk("R4", dq_o, 16'(i * 16'h0403) ^ 16'hA5C3);
        end

        // R7: request pending but edge not yet seen
        mode_set = 1'b1; mode_sel = 2'd1;
        #1 chk("R7", dq_o, arr_data);
        tick();
        mode_set = 1'b0;

        // R5: signature codes
        for (int a = 0; a < 16; a++) begin
            addr = 20'(a * 20'h0B001);
            #1 chk("R5", dq_o, addr[0] ? 16'h0090 : 16'h0020);
        end

        // R6 / R7: status mode
        status_in = 8'h5A;
        mode_set = 1'b1; mode_sel = 2'd2;
        addr = 20'h0;
        #1 chk("R7", dq_o, 16'h0020);
        tick();
        mode_set = 1'b0;
        #1 chk("R6", dq_o, 16'h005A);
        for (int v = 0; v < 256; v += 17) begin
            logic [7:0] prev;
            prev = status_in;
            status_in = 8'(v ^ 8'hC3);
            #1 chk("R6", dq_o, {8'h00, prev});
            tick();
            #1 chk("R6", dq_o, {8'h00, 8'(v ^ 8'hC3)});
        end

        // R7: reserved encoding keeps the mode
        set_mode(2'd3);
        #1 chk("R7", dq_o, {8'h00, status_in});
        set_mode(2'd0);
        arr_data = 16'h7E81;
        #1 chk("R7", dq_o, 16'h7E81);

        // R8 / R9 / R10: write capture variants
        do_write(20'hABCDE, 16'hC3A5, 0, 1);
        do_write(20'h12345, 16'h9F60, 1, 1);
        do_write(20'h0F0F1, 16'h55AA, 2, 3);
        for (int k = 0; k < 12; k++)
            do_write(20'(k * 20'h2F51 + 3), 16'(k * 16'h1357 + 16'h8001), k % 3, 1 + (k % 2));

        // R3: reset from signature mode returns to array
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        set_mode(2'd1);
        addr = 20'h1;
        #1 chk("R5", dq_o, 16'h0090);
        rst = 1'b1;
        tick();
        #1 chk("R2", dq_en, 1'b0);
        rst = 1'b0;
        arr_data = 16'h0C0D;
        #1 chk("R3", dq_o, 16'h0C0D);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule